// File: doc/BRIEF.md
# Packed 32-bit Lane Shuffle Unit

This block builds a 128-bit result vector from two 128-bit operands, a destination vector and a source vector, each seen as four 32-bit lanes. An 8-bit control word is read as four 2-bit lane indices, one for each result lane. The two low result lanes each pick any lane of the destination vector. The two high result lanes each pick any lane of the source vector. When both operands carry the same vector, the unit can produce any lane permutation of it, including a broadcast of one lane to all four.

Inputs are accepted on a cycle where `in_valid` is high. The shuffled vector and a valid flag are registered on the next rising clock edge. A two-state occupancy machine drives the valid flag. `ST_EMPTY` means no result is held and `ST_FULL` means a fresh result is on `out_vec`. The transition `T_ACCEPT` (any state, `in_valid`=1) goes to `ST_FULL`. The transition `T_DRAIN` (any state, `in_valid`=0) goes to `ST_EMPTY`. Synchronous reset forces `ST_EMPTY`.

Top module: `lane_shuffle_unit`

## Requirements
- R1: Result lane 0 (`out_vec[31:0]`) equals the destination lane selected by `ctrl[1:0]`. Lane index n means bits [32n+31:32n].
- R2: Result lane 1 (`out_vec[63:32]`) equals the destination lane selected by `ctrl[3:2]`.
- R3: Result lane 2 (`out_vec[95:64]`) equals the source lane selected by `ctrl[5:4]`.
- R4: Result lane 3 (`out_vec[127:96]`) equals the source lane selected by `ctrl[7:6]`.
- R5: With identical operands, control 0xAA places operand lane 2 in all four result lanes. Control 0x1B reverses the lane order.
- R6: A cycle with `in_valid`=1 makes `out_valid`=1 after the next rising edge, with the matching result on `out_vec` at that same edge.
- R7: A cycle with `in_valid`=0 makes `out_valid`=0 after the next rising edge, and `out_vec` keeps its previous value.
- R8: Synchronous reset (`rst`=1 at a rising edge) clears `out_valid` and sets `out_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept strobe for operands and control |
| dst_vec | input | 128 | Destination operand, feeds result lanes 0 and 1 |
| src_vec | input | 128 | Source operand, feeds result lanes 2 and 3 |
| ctrl | input | 8 | Four 2-bit lane indices, result lane k uses bits [2k+1:2k] |
| out_valid | output | 1 | Result on `out_vec` is fresh |
| out_vec | output | 128 | Registered shuffled vector |

## Verification
On every cycle, the assertions check the following:
- each result lane against the lane picked one cycle earlier from the right operand;
- the valid flag following the strobe;
- the output holding during idle cycles;
- the clearing done by reset.

Only the bench scenarios show the permutation properties of shared operands, such as broadcast and reversal. The same applies to long random sequences that mix accepted and idle cycles, and to a reset taken in the middle of a stream.

// File: rtl/lane_shuf_pkg.sv
package lane_shuf_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } occ_state_t;
endpackage

// File: rtl/lane_pick.sv
module lane_pick #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int SEL_W = $clog2(LANES),
    localparam int VEC_W = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);
    // Mux over every lane: compare index, OR in the match.
    always_comb begin
        lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i))
                lane = vec[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
    import lane_shuf_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int SEL_W  = $clog2(LANES),
    localparam int VEC_W  = LANE_W * LANES,
    localparam int CTRL_W = SEL_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  dst_vec,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_vec
);
    occ_state_t state_q, state_d;
    logic [VEC_W-1:0] shuf_w;

    // Lower half of result lanes from destination, upper half from source.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < LANES / 2) begin : g_dst
            lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick (
                .vec  (dst_vec),
                .sel  (ctrl[g*SEL_W +: SEL_W]),
                .lane (shuf_w[g*LANE_W +: LANE_W])
            );
        end else begin : g_src
            lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) u_pick (
                .vec  (src_vec),
                .sel  (ctrl[g*SEL_W +: SEL_W]),
                .lane (shuf_w[g*LANE_W +: LANE_W])
            );
        end
    end

    // Next-state: T_ACCEPT / T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst)           out_vec <= '0;
        else if (in_valid) out_vec <= shuf_w;
    end

    assign out_valid = (state_q == ST_FULL);

    AST_LANE0_DST: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_vec[0 +: LANE_W] == $past(dst_vec[ctrl[0 +: SEL_W]*LANE_W +: LANE_W])); // R1
    AST_LANE1_DST: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_vec[LANE_W +: LANE_W] == $past(dst_vec[ctrl[SEL_W +: SEL_W]*LANE_W +: LANE_W])); // R2
    AST_LANE2_SRC: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_vec[2*LANE_W +: LANE_W] == $past(src_vec[ctrl[2*SEL_W +: SEL_W]*LANE_W +: LANE_W])); // R3
    AST_LANE3_SRC: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_vec[3*LANE_W +: LANE_W] == $past(src_vec[ctrl[3*SEL_W +: SEL_W]*LANE_W +: LANE_W])); // R4
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R6
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0)); // R8
endmodule

// File: tb/test_lane_shuffle_unit.sv
module test_lane_shuffle_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] dst_vec, src_vec;
    logic [7:0]   ctrl;
    logic         out_valid;
    logic [127:0] out_vec;

    int errors = 0;
    int checks = 0;
    logic [127:0] last_exp = '0;

    always #2 clk = ~clk;  // 250 MHz

    lane_shuffle_unit i_lane_shuffle_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .dst_vec(dst_vec), .src_vec(src_vec), .ctrl(ctrl),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [31:0] lane_of(input logic [127:0] v, input logic [1:0] i);
        return v[32*i +: 32];
    endfunction

    function automatic logic [127:0] ref_shuf(input logic [127:0] d, input logic [127:0] s,
                                              input logic [7:0] c);
        return {lane_of(s, c[7:6]), lane_of(s, c[5:4]), lane_of(d, c[3:2]), lane_of(d, c[1:0])};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [127:0] d, input logic [127:0] s, input logic [7:0] c,
                         input string tag);
        logic [127:0] e;
        @(negedge clk);
        in_valid = 1'b1; dst_vec = d; src_vec = s; ctrl = c;
        e = ref_shuf(d, s, c);
        @(posedge clk); #1;
        check("R1", {96'd0, out_vec[31:0]},   {96'd0, e[31:0]});
        check("R2", {96'd0, out_vec[63:32]},  {96'd0, e[63:32]});
        check("R3", {96'd0, out_vec[95:64]},  {96'd0, e[95:64]});
        check("R4", {96'd0, out_vec[127:96]}, {96'd0, e[127:96]});
        check({"R6 ", tag}, {127'd0, out_valid}, 128'd1);
        last_exp = e;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; dst_vec = '1; src_vec = '1; ctrl = 8'hFF;
        @(posedge clk); #1;
        check("R7 valid", {127'd0, out_valid}, 128'd0);
        check("R7 hold", out_vec, last_exp);
    endtask

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] v;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; dst_vec = '0; src_vec = '0; ctrl = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R8 valid", {127'd0, out_valid}, 128'd0);
        check("R8 data", out_vec, 128'd0);
        @(negedge clk); rst = 1'b0;

        // R1-style directed: identity pass-through
        apply(128'h33333333_22222222_11111111_00000000,
              128'h77777777_66666666_55555555_44444444, 8'hE4, "identity");
        idle();
        // R5: broadcast lane 2 with shared operand
        v = 128'hDDDD0003_CCCC0002_BBBB0001_AAAA0000;
        apply(v, v, 8'hAA, "bcast");
        check("R5 bcast", out_vec, {4{v[95:64]}});
        // R5: reversal with shared operand
        apply(v, v, 8'h1B, "reverse");
        check("R5 reverse", out_vec, {v[31:0], v[63:32], v[95:64], v[127:96]});
        // extremes of lane index
        apply({4{32'hFFFF_FFFF}} ^ v, v, 8'h00, "idx0");
        apply(v, ~v, 8'hFF, "idx3");
        idle();
        idle();

        for (int n = 0; n < 60; n++) begin
            logic [127:0] d, s;
            d = {$urandom, $urandom, $urandom, $urandom};
            s = {$urandom, $urandom, $urandom, $urandom};
            if (($urandom % 4) == 0) idle();
            apply(d, s, 8'($urandom), "random");
        end

        // R8: reset mid-stream
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        check("R8 mid valid", {127'd0, out_valid}, 128'd0);
        check("R8 mid data", out_vec, 128'd0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        last_exp = '0;
        apply(v, ~v, 8'h4E, "after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule